// File: doc/BRIEF.md
# Dual Integer-N Synthesizer Digital Core

This block holds the digital half of two independent integer-N frequency synthesizers, one serving an intermediate-frequency loop and one serving a radio-frequency loop. Each loop divides a shared reference input and its own oscillator-derived input by programmable ratios. A phase-frequency detector compares the two divided edges and produces pump-up and pump-down pulses for an external charge pump. Each loop runs at the reference frequency times its main ratio divided by its reference ratio. The two loops have different legal ratio ranges, and an out-of-range ratio is pulled to the nearest legal value.

Each loop also watches the width of its detector pulses, counted in reference-input edges, to decide whether it is locked. While a loop is still acquiring frequency and its turbo enable is set, the charge-pump current select is forced to its highest code. Once lock is found, the select falls back to the programmed code on its own. The intermediate loop has one turbo enable. The radio loop has two, each reported on its own boost line. A 2-bit mode picks which lock state drives a single open-drain-style lock indicator.

All inputs, including the reference and oscillator inputs, are sampled on one system clock. A rising level between two samples counts as one input edge.

Top module: `dual_synth_core`

## Requirements
- R1: The IF reference divider emits one divided edge per N reference-input edges, where N is the programmed 11-bit ratio limited to the range 2..2047 (a value below 2 acts as 2).
- R2: The IF main divider emits one divided edge per N IF oscillator edges, N being the 14-bit ratio limited to 256..16383 (a value below 256 acts as 256).
- R3: The RF reference divider emits one divided edge per N reference-input edges, N being the 13-bit ratio limited to 2..8191 (below 2 acts as 2).
- R4: The RF main divider emits one divided edge per N RF oscillator edges, N being the 18-bit ratio limited to 4096..262143 (below 4096 acts as 4096).
- R5: A divided reference edge sets the loop's UP output and a divided main edge sets its DN output. The cycle after both are high, both are low.
- R6: A loop becomes locked after 16 consecutive comparisons in which the active pulse spans fewer than 2 reference-input edges. It becomes unlocked as soon as an active pulse spans 2 such edges.
- R7: While a loop is unlocked and any of its turbo enables is set, its current select reads 2'b11. Otherwise the select equals the programmed 2-bit code.
- R8: Each boost bit is high exactly while its own turbo enable is set and its loop is unlocked. The RF loop has two boost bits and the IF loop has one.
- R9: lock_low is low only when the selected lock is present. Mode 0 selects the IF lock, mode 1 the RF lock, mode 2 requires both loops, and mode 3 keeps lock_low high.
- R10: After reset, UP and DN of both loops are low, both loops are unlocked and lock_low is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference input shared by both loops |
| if_vco_in | input | 1 | IF oscillator-derived input |
| rf_vco_in | input | 1 | RF oscillator-derived input |
| if_ref_ratio | input | 11 | IF reference divide ratio |
| if_main_ratio | input | 14 | IF main divide ratio |
| rf_ref_ratio | input | 13 | RF reference divide ratio |
| rf_main_ratio | input | 18 | RF main divide ratio |
| if_cp_code | input | 2 | Programmed IF charge-pump current code |
| rf_cp_code | input | 2 | Programmed RF charge-pump current code |
| if_turbo_en | input | 1 | IF turbo enable |
| rf_turbo_en | input | 2 | RF turbo enables, one per boost path |
| lock_mode | input | 2 | Lock indicator source select |
| if_up | output | 1 | IF pump-up pulse |
| if_dn | output | 1 | IF pump-down pulse |
| rf_up | output | 1 | RF pump-up pulse |
| rf_dn | output | 1 | RF pump-down pulse |
| if_cp_sel | output | 2 | IF charge-pump current select |
| rf_cp_sel | output | 2 | RF charge-pump current select |
| if_boost | output | 1 | IF turbo boost active |
| rf_boost | output | 2 | RF turbo boost active, one bit per enable |
| lock_low | output | 1 | Lock indicator pull-down: 1 pulls the line low (not locked) |

## Verification
On every cycle, the assertions check the detector's one-cycle clear after both pulses are high and the agreement between boost bits and the forced current code. They also check that boost follows only enabled bits, that mode 3 keeps the indicator released, and that the outputs are quiet after reset. The exact divide counts at both edges of each legal range, the 16-comparison lock qualification with real divided waveforms, the fall-back of the current code once lock is found, and loss of lock when an oscillator stops can only be shown by the bench's scenarios.

// File: rtl/synth_pkg.sv
package synth_pkg;
  typedef enum logic [1:0] {
    LK_IF   = 2'd0,
    LK_RF   = 2'd1,
    LK_BOTH = 2'd2,
    LK_OFF  = 2'd3
  } lock_sel_e;

  localparam logic [1:0] CP_FULL = 2'b11;
endpackage

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int W    = 11,
  parameter int LO   = 2,
  parameter int HI   = 2047
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         edge_in,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  logic [W-1:0] eff;
  logic [W-1:0] cnt;

  // limit the programmed ratio to the legal window
  always_comb begin
    if (ratio < LO_V)      eff = LO_V;
    else if (ratio > HI_V) eff = HI_V;
    else                   eff = ratio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (edge_in) begin
        if (cnt >= eff - W'(1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/phase_detector.sv
module phase_detector (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic main_tick,
  output logic up,
  output logic dn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (up && dn) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      if (ref_tick)  up <= 1'b1;
      if (main_tick) dn <= 1'b1;
    end
  end
endmodule

// File: rtl/lock_turbo.sv
module lock_turbo #(
  parameter int LOCK_CYCLES = 16,
  parameter int SPAN_LIMIT  = 2,
  parameter int TURBO_N     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up,
  input  logic               dn,
  input  logic               ref_edge,
  input  logic [1:0]         cp_code,
  input  logic [TURBO_N-1:0] turbo_en,
  output logic               locked,
  output logic [1:0]         cp_sel,
  output logic [TURBO_N-1:0] boost
);
  import synth_pkg::*;

  localparam int GW = $clog2(LOCK_CYCLES + 1);
  localparam int SW = $clog2(SPAN_LIMIT + 1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(LOCK_CYCLES);
  localparam logic [SW-1:0] SPAN_TOP = SW'(SPAN_LIMIT);

  logic [GW-1:0] good;
  logic [SW-1:0] span;
  logic          too_wide;

  assign too_wide = (span == SPAN_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      good   <= '0;
      span   <= '0;
      locked <= 1'b0;
    end else begin
      if (up && dn) begin
        span <= '0;
        if (!too_wide && good != GOOD_TOP) good <= good + GW'(1);
      end else if ((up || dn) && ref_edge && !too_wide) begin
        span <= span + SW'(1);
      end
      if (too_wide) begin
        good   <= '0;
        locked <= 1'b0;
      end else if (good == GOOD_TOP) begin
        locked <= 1'b1;
      end
    end
  end

  // current select and per-enable boost, one cycle behind the lock state
  always_ff @(posedge clk) begin
    if (rst) cp_sel <= '0;
    else     cp_sel <= (|turbo_en && !locked) ? CP_FULL : cp_code;
  end

  for (genvar g = 0; g < TURBO_N; g++) begin : g_boost
    always_ff @(posedge clk) begin
      if (rst) boost[g] <= 1'b0;
      else     boost[g] <= turbo_en[g] && !locked;
    end
  end
endmodule

// File: rtl/synth_loop.sv
module synth_loop #(
  parameter int REF_W       = 11,
  parameter int REF_LO      = 2,
  parameter int REF_HI      = 2047,
  parameter int MAIN_W      = 14,
  parameter int MAIN_LO     = 256,
  parameter int MAIN_HI     = 16383,
  parameter int LOCK_CYCLES = 16,
  parameter int SPAN_LIMIT  = 2,
  parameter int TURBO_N     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_edge,
  input  logic               vco_edge,
  input  logic [REF_W-1:0]   ref_ratio,
  input  logic [MAIN_W-1:0]  main_ratio,
  input  logic [1:0]         cp_code,
  input  logic [TURBO_N-1:0] turbo_en,
  output logic               up,
  output logic               dn,
  output logic               locked,
  output logic [1:0]         cp_sel,
  output logic [TURBO_N-1:0] boost
);
  logic ref_tick, main_tick;

  ratio_divider #(.W(REF_W), .LO(REF_LO), .HI(REF_HI)) u_ref_div (
    .clk(clk), .rst(rst), .edge_in(ref_edge), .ratio(ref_ratio), .tick(ref_tick)
  );

  ratio_divider #(.W(MAIN_W), .LO(MAIN_LO), .HI(MAIN_HI)) u_main_div (
    .clk(clk), .rst(rst), .edge_in(vco_edge), .ratio(main_ratio), .tick(main_tick)
  );

  phase_detector u_pfd (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .main_tick(main_tick), .up(up), .dn(dn)
  );

  lock_turbo #(.LOCK_CYCLES(LOCK_CYCLES), .SPAN_LIMIT(SPAN_LIMIT), .TURBO_N(TURBO_N)) u_lock (
    .clk(clk), .rst(rst), .up(up), .dn(dn), .ref_edge(ref_edge), .cp_code(cp_code),
    .turbo_en(turbo_en), .locked(locked), .cp_sel(cp_sel), .boost(boost)
  );
endmodule

// File: rtl/dual_synth_core.sv
module dual_synth_core #(
  parameter int IF_REF_W    = 11,
  parameter int IF_REF_LO   = 2,
  parameter int IF_REF_HI   = 2047,
  parameter int IF_MAIN_W   = 14,
  parameter int IF_MAIN_LO  = 256,
  parameter int IF_MAIN_HI  = 16383,
  parameter int RF_REF_W    = 13,
  parameter int RF_REF_LO   = 2,
  parameter int RF_REF_HI   = 8191,
  parameter int RF_MAIN_W   = 18,
  parameter int RF_MAIN_LO  = 4096,
  parameter int RF_MAIN_HI  = 262143,
  parameter int LOCK_CYCLES = 16,
  parameter int SPAN_LIMIT  = 2,
  parameter int IF_TURBO_N  = 1,
  parameter int RF_TURBO_N  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_in,
  input  logic                  if_vco_in,
  input  logic                  rf_vco_in,
  input  logic [IF_REF_W-1:0]   if_ref_ratio,
  input  logic [IF_MAIN_W-1:0]  if_main_ratio,
  input  logic [RF_REF_W-1:0]   rf_ref_ratio,
  input  logic [RF_MAIN_W-1:0]  rf_main_ratio,
  input  logic [1:0]            if_cp_code,
  input  logic [1:0]            rf_cp_code,
  input  logic [IF_TURBO_N-1:0] if_turbo_en,
  input  logic [RF_TURBO_N-1:0] rf_turbo_en,
  input  logic [1:0]            lock_mode,
  output logic                  if_up,
  output logic                  if_dn,
  output logic                  rf_up,
  output logic                  rf_dn,
  output logic [1:0]            if_cp_sel,
  output logic [1:0]            rf_cp_sel,
  output logic [IF_TURBO_N-1:0] if_boost,
  output logic [RF_TURBO_N-1:0] rf_boost,
  output logic                  lock_low
);
  import synth_pkg::*;

  logic ref_q, ifv_q, rfv_q;
  logic ref_edge, ifv_edge, rfv_edge;
  logic if_locked, rf_locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      ifv_q <= 1'b0;
      rfv_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
      ifv_q <= if_vco_in;
      rfv_q <= rf_vco_in;
    end
  end

  assign ref_edge = ref_in && !ref_q;
  assign ifv_edge = if_vco_in && !ifv_q;
  assign rfv_edge = rf_vco_in && !rfv_q;

  synth_loop #(
    .REF_W(IF_REF_W), .REF_LO(IF_REF_LO), .REF_HI(IF_REF_HI),
    .MAIN_W(IF_MAIN_W), .MAIN_LO(IF_MAIN_LO), .MAIN_HI(IF_MAIN_HI),
    .LOCK_CYCLES(LOCK_CYCLES), .SPAN_LIMIT(SPAN_LIMIT), .TURBO_N(IF_TURBO_N)
  ) u_if (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .vco_edge(ifv_edge),
    .ref_ratio(if_ref_ratio), .main_ratio(if_main_ratio), .cp_code(if_cp_code),
    .turbo_en(if_turbo_en), .up(if_up), .dn(if_dn), .locked(if_locked),
    .cp_sel(if_cp_sel), .boost(if_boost)
  );

  synth_loop #(
    .REF_W(RF_REF_W), .REF_LO(RF_REF_LO), .REF_HI(RF_REF_HI),
    .MAIN_W(RF_MAIN_W), .MAIN_LO(RF_MAIN_LO), .MAIN_HI(RF_MAIN_HI),
    .LOCK_CYCLES(LOCK_CYCLES), .SPAN_LIMIT(SPAN_LIMIT), .TURBO_N(RF_TURBO_N)
  ) u_rf (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .vco_edge(rfv_edge),
    .ref_ratio(rf_ref_ratio), .main_ratio(rf_main_ratio), .cp_code(rf_cp_code),
    .turbo_en(rf_turbo_en), .up(rf_up), .dn(rf_dn), .locked(rf_locked),
    .cp_sel(rf_cp_sel), .boost(rf_boost)
  );

  // R9: indicator source select, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_low <= 1'b1;
    end else begin
      case (lock_sel_e'(lock_mode))
        LK_IF:   lock_low <= !if_locked;
        LK_RF:   lock_low <= !rf_locked;
        LK_BOTH: lock_low <= !(if_locked && rf_locked);
        default: lock_low <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dual_synth_checker.sv
module dual_synth_checker #(
  parameter int IF_TURBO_N = 1,
  parameter int RF_TURBO_N = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            if_cp_code,
  input logic [1:0]            rf_cp_code,
  input logic [IF_TURBO_N-1:0] if_turbo_en,
  input logic [RF_TURBO_N-1:0] rf_turbo_en,
  input logic [1:0]            lock_mode,
  input logic                  if_up,
  input logic                  if_dn,
  input logic                  rf_up,
  input logic                  rf_dn,
  input logic [1:0]            if_cp_sel,
  input logic [1:0]            rf_cp_sel,
  input logic [IF_TURBO_N-1:0] if_boost,
  input logic [RF_TURBO_N-1:0] rf_boost,
  input logic                  lock_low
);
  // R5: detector clears both pulses the cycle after both are high
  a_r5_if_pfd_clear: assert property (@(posedge clk) disable iff (rst)
    (if_up && if_dn) |=> (!if_up && !if_dn));
  a_r5_rf_pfd_clear: assert property (@(posedge clk) disable iff (rst)
    (rf_up && rf_dn) |=> (!rf_up && !rf_dn));

  // R7: any active boost forces the full current code
  a_r7_if_boost_full: assert property (@(posedge clk) disable iff (rst)
    (|if_boost) |-> (if_cp_sel == 2'b11));
  a_r7_rf_boost_full: assert property (@(posedge clk) disable iff (rst)
    (|rf_boost) |-> (rf_cp_sel == 2'b11));

  // R7: with no boost the programmed code passes through
  a_r7_if_code_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && if_boost == '0) |-> (if_cp_sel == $past(if_cp_code)));
  a_r7_rf_code_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rf_boost == '0) |-> (rf_cp_sel == $past(rf_cp_code)));

  // R8: a boost bit only follows its own enable
  a_r8_rf_boost_enabled: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((rf_boost & ~$past(rf_turbo_en)) == '0));

  // R9: mode 3 keeps the indicator released
  a_r9_mode_off: assert property (@(posedge clk) disable iff (rst)
    (lock_mode == 2'd3) |=> lock_low);

  // R10: quiet outputs right after reset
  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!if_up && !if_dn && !rf_up && !rf_dn && lock_low));
endmodule

bind dual_synth_core dual_synth_checker #(.IF_TURBO_N(IF_TURBO_N), .RF_TURBO_N(RF_TURBO_N)) u_chk (.*);

// File: tb/dual_synth_core_bench.sv
module dual_synth_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic man_ref = 1'b0, man_ifv = 1'b0, man_rfv = 1'b0;
  logic gen_on = 1'b0, gen_ifv = 1'b0, gen_rfv = 1'b0;
  logic [3:0] rc;
  logic vc;
  logic ref_in, if_vco_in, rf_vco_in;
  logic [10:0] if_ref_ratio;
  logic [13:0] if_main_ratio;
  logic [12:0] rf_ref_ratio;
  logic [17:0] rf_main_ratio;
  logic [1:0] if_cp_code, rf_cp_code, lock_mode;
  logic [0:0] if_turbo_en;
  logic [1:0] rf_turbo_en;
  logic if_up, if_dn, rf_up, rf_dn, lock_low;
  logic [1:0] if_cp_sel, rf_cp_sel;
  logic [0:0] if_boost;
  logic [1:0] rf_boost;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // free-running stimulus: ref every 16 clk, oscillators every 2 clk
  always @(negedge clk) begin
    if (!gen_on) begin
      rc <= '0;
      vc <= 1'b0;
    end else begin
      rc <= rc + 4'd1;
      vc <= ~vc;
    end
  end

  assign ref_in    = man_ref | (gen_on && rc == 4'd0);
  assign if_vco_in = man_ifv | (gen_on && gen_ifv && !vc);
  assign rf_vco_in = man_rfv | (gen_on && gen_rfv && !vc);

  dual_synth_core u_dual_synth_core (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // {loop(0 IF,1 RF), divider(0 ref,1 main), programmed[17:0], expected[17:0]}
  localparam logic [37:0] VEC [9] = '{
    {1'b0, 1'b0, 18'd0,    18'd2},
    {1'b0, 1'b0, 18'd5,    18'd5},
    {1'b0, 1'b0, 18'd2047, 18'd2047},
    {1'b0, 1'b1, 18'd100,  18'd256},
    {1'b0, 1'b1, 18'd300,  18'd300},
    {1'b1, 1'b0, 18'd1,    18'd2},
    {1'b1, 1'b0, 18'd9,    18'd9},
    {1'b1, 1'b1, 18'd5,    18'd4096},
    {1'b1, 1'b1, 18'd4100, 18'd4100}
  };

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    if_ref_ratio = 11'd2; if_main_ratio = 14'd256;
    rf_ref_ratio = 13'd2; rf_main_ratio = 18'd4096;
    if_cp_code = 2'b01; rf_cp_code = 2'b10;
    if_turbo_en = 1'b1; rf_turbo_en = 2'b11; lock_mode = 2'd0;
    do_reset();

    // R10: reset state
    chk(!if_up && !if_dn && !rf_up && !rf_dn, "R10 pulses idle", int'(if_up | if_dn | rf_up | rf_dn), 0);
    chk(lock_low == 1'b1, "R10 lock_low", int'(lock_low), 1);

    // R7/R8: turbo off passes the code; RF boost follows its enables
    if_turbo_en = 1'b0; rf_turbo_en = 2'b10;
    repeat (2) @(negedge clk);
    chk(if_cp_sel == 2'b01, "R7 turbo off code", int'(if_cp_sel), 1);
    chk(if_boost == 1'b0, "R8 IF boost off", int'(if_boost), 0);
    chk(rf_boost == 2'b10, "R8 RF boost per enable", int'(rf_boost), 2);
    chk(rf_cp_sel == 2'b11, "R7 RF turbo full", int'(rf_cp_sel), 3);

    // R1-R4: divide counts and clamping
    for (int v = 0; v < 9; v++) begin
      logic is_rf, is_main;
      logic [17:0] prog, expv;
      int seen;
      {is_rf, is_main, prog, expv} = VEC[v];
      if_ref_ratio = 11'd2047; if_main_ratio = 14'd16383;
      rf_ref_ratio = 13'd8191; rf_main_ratio = 18'd262143;
      if (!is_rf && !is_main) if_ref_ratio  = prog[10:0];
      if (!is_rf &&  is_main) if_main_ratio = prog[13:0];
      if ( is_rf && !is_main) rf_ref_ratio  = prog[12:0];
      if ( is_rf &&  is_main) rf_main_ratio = prog;
      do_reset();
      seen = -1;
      for (int k = 1; k <= int'(expv) + 4; k++) begin
        if (!is_main) man_ref = 1'b1;
        else if (!is_rf) man_ifv = 1'b1;
        else man_rfv = 1'b1;
        @(negedge clk);
        man_ref = 1'b0; man_ifv = 1'b0; man_rfv = 1'b0;
        @(negedge clk);
        if (( is_main && ((!is_rf && if_dn) || (is_rf && rf_dn))) ||
            (!is_main && ((!is_rf && if_up) || (is_rf && rf_up)))) begin
          seen = k;
          break;
        end
      end
      if (!is_rf && !is_main)     chk(seen == int'(expv), "R1 IF ref divide", seen, int'(expv));
      else if (!is_rf)            chk(seen == int'(expv), "R2 IF main divide", seen, int'(expv));
      else if (!is_main)          chk(seen == int'(expv), "R3 RF ref divide", seen, int'(expv));
      else                        chk(seen == int'(expv), "R4 RF main divide", seen, int'(expv));
    end

    // R5: UP then DN, both high one cycle, then both low
    if_ref_ratio = 11'd2; if_main_ratio = 14'd256;
    do_reset();
    for (int k = 0; k < 2; k++) begin
      man_ref = 1'b1; @(negedge clk); man_ref = 1'b0; @(negedge clk);
    end
    chk(if_up && !if_dn, "R5 UP set by ref", int'({if_up, if_dn}), 2);
    for (int k = 0; k < 256; k++) begin
      man_ifv = 1'b1; @(negedge clk); man_ifv = 1'b0; @(negedge clk);
    end
    chk(if_up && if_dn, "R5 both high", int'({if_up, if_dn}), 3);
    @(negedge clk);
    chk(!if_up && !if_dn, "R5 both cleared", int'({if_up, if_dn}), 0);

    // R6/R7/R8/R9: lock acquisition with matched frequencies
    if_ref_ratio = 11'd32; if_main_ratio = 14'd256;
    rf_ref_ratio = 13'd512; rf_main_ratio = 18'd4096;
    if_turbo_en = 1'b1; rf_turbo_en = 2'b11; lock_mode = 2'd0;
    do_reset();
    gen_ifv = 1'b1; gen_rfv = 1'b1; gen_on = 1'b1;
    repeat (2500) @(negedge clk);
    chk(if_cp_sel == 2'b11, "R7 IF turbo while acquiring", int'(if_cp_sel), 3);
    chk(if_boost == 1'b1, "R8 IF boost while acquiring", int'(if_boost), 1);
    chk(lock_low == 1'b1, "R6 not yet locked", int'(lock_low), 1);
    repeat (9500) @(negedge clk);
    chk(lock_low == 1'b0, "R6 IF locked mode 0", int'(lock_low), 0);
    chk(if_cp_sel == 2'b01, "R7 IF code after lock", int'(if_cp_sel), 1);
    chk(if_boost == 1'b0, "R8 IF boost off after lock", int'(if_boost), 0);
    lock_mode = 2'd1; repeat (2) @(negedge clk);
    chk(lock_low == 1'b1, "R9 mode 1 RF not locked", int'(lock_low), 1);
    lock_mode = 2'd2; repeat (2) @(negedge clk);
    chk(lock_low == 1'b1, "R9 mode 2 needs both", int'(lock_low), 1);
    repeat (122000) @(negedge clk);
    lock_mode = 2'd1; repeat (2) @(negedge clk);
    chk(lock_low == 1'b0, "R9 mode 1 RF locked", int'(lock_low), 0);
    chk(rf_cp_sel == 2'b10, "R7 RF code after lock", int'(rf_cp_sel), 2);
    chk(rf_boost == 2'b00, "R8 RF boost off after lock", int'(rf_boost), 0);
    lock_mode = 2'd2; repeat (2) @(negedge clk);
    chk(lock_low == 1'b0, "R9 mode 2 both locked", int'(lock_low), 0);
    lock_mode = 2'd3; repeat (2) @(negedge clk);
    chk(lock_low == 1'b1, "R9 mode 3 released", int'(lock_low), 1);

    // R6: stopping the IF oscillator loses IF lock only
    gen_ifv = 1'b0;
    lock_mode = 2'd0;
    repeat (300) @(negedge clk);
    chk(lock_low == 1'b1, "R6 IF lock lost", int'(lock_low), 1);
    chk(if_cp_sel == 2'b11, "R7 IF turbo back on", int'(if_cp_sel), 3);
    lock_mode = 2'd1; repeat (2) @(negedge clk);
    chk(lock_low == 1'b0, "R6 RF lock kept", int'(lock_low), 0);
    lock_mode = 2'd2; repeat (2) @(negedge clk);
    chk(lock_low == 1'b1, "R9 mode 2 one lost", int'(lock_low), 1);

    gen_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule